// File: doc/BRIEF.md
# Transmit FIR Pre-emphasis Encoder

This block sits in front of a serial transmitter's output driver and turns a stream of NRZ bits into a signed, multi-level drive word. Each bit is treated as +1 or -1 and passed through a four-tap FIR filter. The filter has a unity main tap, one pre-cursor tap that is added, and two post-cursor taps that are subtracted. The effect is that transitions are emphasised and long runs are attenuated, which pre-compensates the low-pass loss of the channel.

The pre-cursor tap needs to see the bit that comes after the one being driven. For that reason the main tap lags the input stream by one sample. Coefficients are unsigned fixed-point magnitudes. A guard compares their total against the driver's peak swing. When a set is too large, the guard flags it and forces the output to full scale instead of producing a distorted code.

A parameter selects one of two spacings:
- **Symbol spacing:** one filter sample per bit.
- **Half-symbol spacing:** each bit is presented twice, on consecutive cycles of a clock running at twice the bit rate. These correspond to the two half-periods of the bit clock, so every delay element spans half a bit.

Top module: `txfir_encoder`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `drive_valid`=0, `drive_code`=0 and `coef_err`=0. Reset also clears the registered coefficients to zero.
- R2: Input level 1 counts as +1 and level 0 counts as -1 in every tap.
- R3: Each filter sample produces one code, computed from the newest sample s0 and the three samples before it (s1, s2, s3) with the registered coefficients: code = pre·s0 + 128·s1 − post1·s2 − post2·s3. Coefficients are unsigned Q1.7 (128 = 1.0), so s1 is the driven main-tap sample.
- R4: The code for a sample is produced on the rising edge at which the following sample is accepted. `drive_valid` is high in the cycle after every accepted input bit.
- R5: After reset, the three history samples hold -1 until real samples replace them.
- R6: `coef_err` goes high one edge after the coefficient inputs satisfy pre + post1 + post2 > 128. A sum of exactly 128 is legal.
- R7: While the registered coefficients are in error, every produced code is +FS when the main-tap sample is +1 and −FS when it is −1, where FS = 2^(OUT_W−1) − 1.
- R8: When no error is flagged, a filter result outside ±FS is clamped to ±FS.
- R9: With half-symbol spacing, each accepted bit yields two filter samples on consecutive cycles. Input bits must be at least two cycles apart.
- R10: `drive_valid` is high for exactly one cycle per filter sample. `drive_code` holds its value in cycles without a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (bit rate, or twice the bit rate with half spacing) |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | Strobe: `bit_in` carries a new bit |
| bit_in | input | 1 | NRZ bit, 1 = +1, 0 = −1 |
| coef_pre | input | COEF_W | Pre-cursor magnitude, unsigned Q1.7 |
| coef_post1 | input | COEF_W | First post-cursor magnitude, unsigned Q1.7 |
| coef_post2 | input | COEF_W | Second post-cursor magnitude, unsigned Q1.7 |
| drive_valid | output | 1 | A new drive code is present |
| drive_code | output | OUT_W | Saturated signed drive word |
| coef_err | output | 1 | Registered coefficient set exceeds the peak budget |

## Verification
The bench builds two instances side by side.

The first uses symbol spacing and a 10-bit output. The largest legal result (±256) fits inside its range, so this instance shows the unclamped filter arithmetic under back-to-back bits, idle gaps and coefficient changes made during streaming.

The second uses half-symbol spacing and an 8-bit output, which limits FS to 127. Even the plain ±128 main tap, and every boundary-sum coefficient set, then reaches the clamp. This instance also exercises the repeated-sample path and its spacing rule.

Both instances are compared every cycle against a behavioural model, including at the legal sum of exactly 128, just past it, and after a second reset in the middle of the run.

// File: rtl/txfir_pkg.sv
// Shared types for the transmit FIR encoder.
// Assumes nothing beyond standard SystemVerilog packed types.
package txfir_pkg;

    // Delay spacing of the filter taps
    typedef enum logic {
        SPACING_FULL = 1'b0,
        SPACING_HALF = 1'b1
    } txfir_spacing_e;

    // One filter sample: presence strobe and NRZ level (1 = +1, 0 = -1)
    typedef struct packed {
        logic valid;
        logic level;
    } txfir_samp_t;

endpackage

// File: rtl/txfir_coef_guard.sv
// Registers the coefficient magnitudes and flags any set whose total
// exceeds the peak budget LIMIT. Assumes unsigned magnitudes; both the
// registered set and the flag change on the same edge, so downstream
// logic always sees a consistent pair.
module txfir_coef_guard #(
    parameter int COEF_W = 8,
    parameter int LIMIT  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COEF_W-1:0] coef_pre,
    input  logic [COEF_W-1:0] coef_post1,
    input  logic [COEF_W-1:0] coef_post2,
    output logic [COEF_W-1:0] cq_pre,
    output logic [COEF_W-1:0] cq_post1,
    output logic [COEF_W-1:0] cq_post2,
    output logic              err_q
);
    localparam int SUM_W = COEF_W + 2;

    logic [SUM_W-1:0] mag_sum;
    logic             over_budget;

    // Total magnitude of the three side taps
    always_comb begin
        mag_sum = SUM_W'(coef_pre) + SUM_W'(coef_post1) + SUM_W'(coef_post2);
        over_budget = (int'(mag_sum) > LIMIT);
    end

    // Capture coefficients and their budget check together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cq_pre   <= '0;
            cq_post1 <= '0;
            cq_post2 <= '0;
            err_q    <= 1'b0;
        end else begin
            cq_pre   <= coef_pre;
            cq_post1 <= coef_post1;
            cq_post2 <= coef_post2;
            err_q    <= over_budget;
        end
    end

    AST_ZERO_SET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_pre == '0 && coef_post1 == '0 && coef_post2 == '0) |=> !err_q); // R6

endmodule

// File: rtl/txfir_tap_sum.sv
// Holds the three-sample history and forms the weighted sum
// pre*s0 + 1.0*s1 - post1*s2 - post2*s3, where s0 is the arriving sample.
// Saturates to +-FS. While the coefficient set is in error, it forces
// full scale with the sign of the main tap. Assumes the history resets
// to -1 (idle low).
module txfir_tap_sum
    import txfir_pkg::*;
#(
    parameter int COEF_W = 8,
    parameter int OUT_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  txfir_samp_t             samp,
    input  logic [COEF_W-1:0]       cq_pre,
    input  logic [COEF_W-1:0]       cq_post1,
    input  logic [COEF_W-1:0]       cq_post2,
    input  logic                    err_q,
    output logic                    drive_valid,
    output logic signed [OUT_W-1:0] drive_code
);
    localparam int HIST_D = 3;
    localparam int UNITY  = 1 << (COEF_W - 1);
    localparam int FS     = (1 << (OUT_W - 1)) - 1;

    logic [HIST_D-1:0]       hist_q;
    int                      acc;
    int                      sat;
    logic signed [OUT_W-1:0] code_d;

    // Map an NRZ level to +1 or -1
    function automatic int lvl(input logic b);
        return b ? 1 : -1;
    endfunction

    // Weighted sum, then error override or saturation
    always_comb begin
        acc = int'(cq_pre) * lvl(samp.level)
            + UNITY * lvl(hist_q[0])
            - int'(cq_post1) * lvl(hist_q[1])
            - int'(cq_post2) * lvl(hist_q[2]);
        if (err_q)
            sat = hist_q[0] ? FS : -FS;
        else if (acc > FS)
            sat = FS;
        else if (acc < -FS)
            sat = -FS;
        else
            sat = acc;
        code_d = OUT_W'(sat);
    end

    // Shift history and register the output on each sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q      <= '0;
            drive_valid <= 1'b0;
            drive_code  <= '0;
        end else begin
            drive_valid <= samp.valid;
            if (samp.valid) begin
                hist_q     <= {hist_q[HIST_D-2:0], samp.level};
                drive_code <= code_d;
            end
        end
    end

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !samp.valid |=> $stable(drive_code)); // R10
    AST_ERR_FULLSCALE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && samp.valid) |=> (int'(drive_code) == FS || int'(drive_code) == -FS)); // R7
    AST_CODE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        drive_valid |-> (int'(drive_code) <= FS && int'(drive_code) >= -FS)); // R8

endmodule

// File: rtl/txfir_encoder.sv
// Transmit FIR pre-emphasis encoder top. It turns an NRZ bit stream into
// a saturated signed drive code. With half-symbol spacing, clk runs at
// twice the bit rate: every bit is presented as two samples (one per
// half bit period) and bits must be at least two cycles apart.
module txfir_encoder
    import txfir_pkg::*;
#(
    parameter int             COEF_W  = 8,
    parameter int             OUT_W   = 10,
    parameter txfir_spacing_e SPACING = SPACING_FULL
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_valid,
    input  logic                    bit_in,
    input  logic [COEF_W-1:0]       coef_pre,
    input  logic [COEF_W-1:0]       coef_post1,
    input  logic [COEF_W-1:0]       coef_post2,
    output logic                    drive_valid,
    output logic signed [OUT_W-1:0] drive_code,
    output logic                    coef_err
);
    localparam int LIMIT = 1 << (COEF_W - 1);

    txfir_samp_t       samp;
    logic [COEF_W-1:0] cq_pre;
    logic [COEF_W-1:0] cq_post1;
    logic [COEF_W-1:0] cq_post2;
    logic              err_q;

    generate
        if (SPACING == SPACING_HALF) begin : g_half
            logic rep_q;
            logic rep_lvl_q;

            // Remember the bit so it is replayed in the second half period
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rep_q     <= 1'b0;
                    rep_lvl_q <= 1'b0;
                end else begin
                    rep_q     <= bit_valid;
                    rep_lvl_q <= bit_in;
                end
            end

            assign samp = txfir_samp_t'({bit_valid | rep_q, bit_valid ? bit_in : rep_lvl_q});

            AST_HALF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                bit_valid |=> !bit_valid); // R9
            AST_HALF_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
                bit_valid |=> (samp.valid && samp.level == $past(bit_in))); // R9
        end else begin : g_full
            assign samp = txfir_samp_t'({bit_valid, bit_in});
        end
    endgenerate

    txfir_coef_guard #(
        .COEF_W (COEF_W),
        .LIMIT  (LIMIT)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .coef_pre   (coef_pre),
        .coef_post1 (coef_post1),
        .coef_post2 (coef_post2),
        .cq_pre     (cq_pre),
        .cq_post1   (cq_post1),
        .cq_post2   (cq_post2),
        .err_q      (err_q)
    );

    txfir_tap_sum #(
        .COEF_W (COEF_W),
        .OUT_W  (OUT_W)
    ) u_sum (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp        (samp),
        .cq_pre      (cq_pre),
        .cq_post1    (cq_post1),
        .cq_post2    (cq_post2),
        .err_q       (err_q),
        .drive_valid (drive_valid),
        .drive_code  (drive_code)
    );

    assign coef_err = err_q;

    AST_OUT_AFTER_IN: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> drive_valid); // R4

endmodule

// File: tb/sim_txfir_encoder.sv
// Bench: two encoders (symbol spacing, 10-bit out; half spacing, 8-bit out)
// compared every cycle against a behavioural model.
module sim_txfir_encoder;
    import txfir_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W0 = 10;
    localparam int W1 = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic v0 = 0, b0 = 0, v1 = 0, b1 = 0;
    logic [7:0] cp = 0, c1 = 0, c2 = 0;
    logic dv0, dv1, e0, e1;
    logic signed [W0-1:0] dc0;
    logic signed [W1-1:0] dc1;

    txfir_encoder #(.COEF_W(8), .OUT_W(W0), .SPACING(SPACING_FULL)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_valid(v0), .bit_in(b0),
        .coef_pre(cp), .coef_post1(c1), .coef_post2(c2),
        .drive_valid(dv0), .drive_code(dc0), .coef_err(e0));

    txfir_encoder #(.COEF_W(8), .OUT_W(W1), .SPACING(SPACING_HALF)) u1 (
        .clk(clk), .rst_n(rst_n), .bit_valid(v1), .bit_in(b1),
        .coef_pre(cp), .coef_post1(c1), .coef_post2(c2),
        .drive_valid(dv1), .drive_code(dc1), .coef_err(e1));

    int total = 0;
    int bad = 0;
    string req = "R1";
    bit done = 0;
    bit nx_rst = 0;
    int nx_cp = 0, nx_c1 = 0, nx_c2 = 0;
    bit last1 = 0;

    int m_h[2][3];
    int m_cq[2][3];
    int m_err[2];
    int m_rep[2];
    int m_repb[2];
    int x_v[2];
    int x_c[2];
    int x_e[2];
    int fs[2];

    // Model reset: history -1 (R5), coefficients 0, no error, no outputs (R1)
    task automatic model_reset(input int k);
        for (int j = 0; j < 3; j++) begin
            m_h[k][j] = -1;
            m_cq[k][j] = 0;
        end
        m_err[k] = 0; m_rep[k] = 0; m_repb[k] = 0;
        x_v[k] = 0; x_c[k] = 0; x_e[k] = 0;
    endtask

    // Predict outputs after the coming rising edge
    task automatic predict(input int k, input bit v, input bit b, input bit half);
        bit sv;
        bit sb;
        int sn;
        int acc;
        if (!rst_n) begin
            model_reset(k);
            return;
        end
        sv = v; sb = b;
        if (half && !v && m_rep[k] != 0) begin
            sv = 1; sb = m_repb[k][0];   // R9 second half sample
        end
        if (sv) begin
            sn = sb ? 1 : -1;            // R2
            acc = m_cq[k][0] * sn + 128 * m_h[k][0]
                - m_cq[k][1] * m_h[k][1] - m_cq[k][2] * m_h[k][2];   // R3
            if (m_err[k] != 0)
                acc = (m_h[k][0] > 0) ? fs[k] : -fs[k];              // R7
            else if (acc > fs[k])
                acc = fs[k];                                          // R8
            else if (acc < -fs[k])
                acc = -fs[k];
            x_c[k] = acc;
            x_v[k] = 1;
            m_h[k][2] = m_h[k][1];
            m_h[k][1] = m_h[k][0];
            m_h[k][0] = sn;
        end else begin
            x_v[k] = 0;                                               // R10
        end
        m_err[k] = (int'(cp) + int'(c1) + int'(c2) > 128) ? 1 : 0;    // R6
        x_e[k] = m_err[k];
        m_cq[k][0] = int'(cp); m_cq[k][1] = int'(c1); m_cq[k][2] = int'(c2);
        if (half) begin
            m_rep[k] = v ? 1 : 0;
            m_repb[k] = b ? 1 : 0;
        end
    endtask

    task automatic check_one(input int k, input int av, input int ac, input int ae);
        total++;
        if (av != x_v[k] || ac != x_c[k] || ae != x_e[k]) begin
            bad++;
            $display("FAIL %s u%0d: valid=%0d code=%0d err=%0d expected valid=%0d code=%0d err=%0d",
                     req, k, av, ac, ae, x_v[k], x_c[k], x_e[k]);
        end
    endtask

    // One cycle: compare, then apply inputs and predict
    task automatic step(input bit a0, input bit a1, input bit a2, input bit a3);
        @(negedge clk);
        check_one(0, int'(dv0), int'(dc0), int'(e0));
        check_one(1, int'(dv1), int'(dc1), int'(e1));
        rst_n = nx_rst;
        v0 = a0; b0 = a1; v1 = a2; b1 = a3;
        cp = 8'(nx_cp); c1 = 8'(nx_c1); c2 = 8'(nx_c2);
        predict(0, a0, a1, 1'b0);
        predict(1, a2, a3, 1'b1);
        last1 = a2;
    endtask

    task automatic run_rand(input int n, input int pct);
        for (int i = 0; i < n; i++) begin
            bit a = ($urandom_range(99) < pct);
            bit bb = 1'($urandom_range(1));
            bit c = ($urandom_range(99) < pct) && !last1;
            bit d = 1'($urandom_range(1));
            step(a, bb, c, d);
        end
    endtask

    // kind 0: alternating, 1: runs of five, 2: all ones
    task automatic run_pat(input int n, input int kind);
        for (int i = 0; i < n; i++) begin
            bit lv = (kind == 0) ? 1'(i % 2) : (kind == 1) ? 1'((i / 5) % 2) : 1'b1;
            bit hv = (i % 2 == 0);
            step(1'b1, lv, hv, lv);
        end
    endtask

    task automatic set_coef(input int p, input int q, input int r);
        nx_cp = p; nx_c1 = q; nx_c2 = r;
    endtask

    initial begin
        fs[0] = (1 << (W0 - 1)) - 1;
        fs[1] = (1 << (W1 - 1)) - 1;
        model_reset(0);
        model_reset(1);

        req = "R1 reset state";
        nx_rst = 0;
        repeat (4) step(0, 0, 0, 0);
        nx_rst = 1;
        req = "R5 R2 idle history after reset";
        set_coef(16, 32, 16);
        run_pat(8, 2);
        req = "R3 R4 R9 alternating bits";
        run_pat(40, 0);
        req = "R3 R9 runs of five";
        run_pat(40, 1);
        req = "R3 R10 random bits with gaps";
        run_rand(300, 60);
        req = "R6 R8 sum exactly 128 legal, clamp on 8-bit output";
        set_coef(64, 40, 24);
        run_rand(200, 70);
        req = "R6 R7 sum 129 flagged, full scale";
        set_coef(64, 40, 25);
        run_rand(150, 70);
        req = "R6 R7 maximum coefficients";
        set_coef(255, 255, 255);
        run_rand(60, 80);
        req = "R8 main tap only";
        set_coef(0, 0, 0);
        run_pat(20, 0);
        req = "R10 sparse bits";
        set_coef(0, 20, 10);
        run_rand(300, 25);
        req = "R1 R5 second reset";
        nx_rst = 0;
        repeat (3) step(0, 0, 0, 0);
        nx_rst = 1;
        set_coef(30, 50, 20);
        run_pat(12, 2);
        req = "R3 R4 dense random";
        run_rand(200, 95);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R4: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule